// File: doc/BRIEF.md
# Framed Serial Code Loader

This block collects a digital-to-analogue converter code that arrives one bit per clock on a single serial line. An active-high enable level marks the frame. The block then hands the DAC core a parallel word that stays steady while it is in use. The bit in front of the first rising clock edge with enable high is the least significant bit. Each later edge fills the next higher position, up to bit `CODE_W-1`.

The parallel output keeps its old value while a new frame shifts in. The block finds the end of a frame inside the clock domain, by comparing enable with its value one clock earlier. When the frame ends it either loads the new word and raises a one-cycle update strobe, or throws the frame away and raises a one-cycle error flag. Resolution is a parameter limited to 8, 10 or 12 bits. An option selects how bits are steered into the collection register: shifting or indexed writes.

Top module: `serial_code_loader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `dac_code`, `code_upd` and `frame_err` to zero, together with the bit count.
- R2: The bit on `ser_in` at the first rising edge with `frame_en` high lands in `dac_code[0]`. The bit at the k-th such edge lands in `dac_code[k-1]`.
- R3: `dac_code` keeps its previous value in every cycle except the one right after a complete frame ends.
- R4: If `frame_en` is first sampled low at a rising edge after at least `CODE_W` high samples, the new word appears on `dac_code` after that edge. `code_upd` is high for exactly that one cycle.
- R5: If `frame_en` falls after fewer than `CODE_W` high samples, the frame is discarded. `dac_code` is unchanged, and `frame_err` is high for exactly one cycle at the same timing as `code_upd` in R4.
- R6: Rising edges beyond the first `CODE_W` while `frame_en` is still high are ignored. Such a frame delivers its first `CODE_W` bits and raises no error.
- R7: `code_upd` and `frame_err` are never high in the same cycle.
- R8: A new frame may begin with only one low `frame_en` sample after the previous frame. Both frames are then handled correctly.
- R9: A `CODE_W` other than 8, 10 or 12 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_en | input | 1 | Frame marker, active high |
| ser_in | input | 1 | Serial code bit, least significant first |
| dac_code | output | CODE_W | Parallel code word held for the DAC core |
| code_upd | output | 1 | One-cycle strobe when `dac_code` takes a new word |
| frame_err | output | 1 | One-cycle flag when a short frame is discarded |

## Verification
The bench sends every 8-bit code, so a reversed bit order, or an output that is off by one position, shows up at once as a wrong word.

Frames of every length from 1 to 7 bits must raise the error flag and leave the word untouched. A design that loaded partial words would corrupt the output here. Frames of 9 to 11 bits carry inverted filler bits after the real ones. A design that kept shifting would push the filler into the word.

The output is compared with the last good word at every in-frame cycle. This catches a design that lets the collection register leak out early. Frames separated by a single low cycle catch a bit count that fails to clear in time.

// File: rtl/loader_pkg.sv
package loader_pkg;
   function automatic int count_bits(input int n);
      return $clog2(n + 1);
   endfunction

   function automatic bit width_ok(input int n);
      return (n == 8) || (n == 10) || (n == 12);
   endfunction
endpackage

// File: rtl/frame_edge_det.sv
module frame_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_en,
   output logic frame_end
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= frame_en;
   end

   assign frame_end = en_q & ~frame_en;

   AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> $past(frame_en)); // R4
endmodule

// File: rtl/lsb_collector.sv
module lsb_collector #(
   parameter int CODE_W   = 8,
   parameter bit INDEXED  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_en,
   input  logic              ser_in,
   input  logic              frame_end,
   output logic [CODE_W-1:0] word,
   output logic              full
);
   localparam int CW = loader_pkg::count_bits(CODE_W);
   localparam logic [CW-1:0] LAST = CW'(CODE_W);

   logic [CW-1:0] cnt;
   logic          take;

   assign take = frame_en && (cnt < LAST);
   assign full = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (frame_end) cnt <= '0;
      else if (take)      cnt <= cnt + 1'b1;
   end

   generate
      if (INDEXED) begin : g_indexed
         always_ff @(posedge clk) begin
            if (!rst_n)    word <= '0;
            else if (take) word[cnt[CW-1:0]] <= ser_in;
         end
      end else begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n)    word <= '0;
            else if (take) word <= {ser_in, word[CODE_W-1:1]};
         end
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R6
   AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (cnt == '0)); // R8
endmodule

// File: rtl/code_hold.sv
module code_hold #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              full,
   input  logic [CODE_W-1:0] word,
   output logic [CODE_W-1:0] dac_code,
   output logic              code_upd,
   output logic              frame_err
);
   logic load;
   assign load = frame_end & full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_code  <= '0;
         code_upd  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (load) dac_code <= word;
         code_upd  <= load;
         frame_err <= frame_end & ~full;
      end
   end

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dac_code)); // R3
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err); // R5
endmodule

// File: rtl/serial_code_loader.sv
module serial_code_loader #(
   parameter int CODE_W  = 8,
   parameter bit INDEXED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_en,
   input  logic              ser_in,
   output logic [CODE_W-1:0] dac_code,
   output logic              code_upd,
   output logic              frame_err
);
   generate
      if (!loader_pkg::width_ok(CODE_W)) begin : g_bad_width
         $error("serial_code_loader: CODE_W must be 8, 10 or 12"); // R9
      end
   endgenerate

   logic              frame_end;
   logic              full;
   logic [CODE_W-1:0] word;

   frame_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .frame_end(frame_end)
   );

   lsb_collector #(.CODE_W(CODE_W), .INDEXED(INDEXED)) u_coll (
      .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ser_in(ser_in),
      .frame_end(frame_end), .word(word), .full(full)
   );

   code_hold #(.CODE_W(CODE_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .full(full),
      .word(word), .dac_code(dac_code), .code_upd(code_upd),
      .frame_err(frame_err)
   );

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      code_upd |=> !code_upd); // R4
   AST_UPD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      code_upd |-> (!$past(frame_en) && $past(frame_en, 2))); // R4
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(code_upd && frame_err)); // R7
endmodule

// File: tb/serial_code_loader_bench.sv
module serial_code_loader_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_en = 1'b0;
   logic         ser_in = 1'b0;
   logic [N-1:0] dac_code;
   logic         code_upd;
   logic         frame_err;

   int total = 0;
   int bad = 0;
   logic [N-1:0] exp_code = '0;

   always #5 clk = ~clk;

   serial_code_loader #(.CODE_W(N)) u_serial_code_loader (
      .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ser_in(ser_in),
      .dac_code(dac_code), .code_upd(code_upd), .frame_err(frame_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Caller stands just after a falling clock edge; task returns at a falling edge.
   task automatic send(input logic [N-1:0] val, input int nbits, input string tag);
      frame_en = 1'b1;
      ser_in   = val[0];
      for (int i = 1; i < nbits; i++) begin
         @(negedge clk);
         chk({tag, " R3 hold"}, 32'(dac_code), 32'(exp_code));
         chk({tag, " R7 no strobe in frame"}, {30'b0, code_upd, frame_err}, 32'd0);
         ser_in = (i < N) ? val[i] : ~val[i % N];
      end
      @(negedge clk);
      chk({tag, " R3 hold last bit"}, 32'(dac_code), 32'(exp_code));
      chk({tag, " R7 quiet before end"}, {30'b0, code_upd, frame_err}, 32'd0);
      frame_en = 1'b0;
      ser_in   = 1'b0;
      @(negedge clk);
      if (nbits >= N) exp_code = val;
      chk({tag, " R2 word"}, 32'(dac_code), 32'(exp_code));
      chk({tag, " R4/R5/R6 flags"}, {30'b0, code_upd, frame_err},
          (nbits >= N) ? 32'd2 : 32'd1);
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset code", 32'(dac_code), 32'd0);
      chk("R1 reset flags", {30'b0, code_upd, frame_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4: every code, two idle cycles between frames
      for (int v = 0; v < (1 << N); v++) begin
         send(N'(v), N, "R2 sweep");
         @(negedge clk);
         chk("R4 strobe one cycle", {30'b0, code_upd, frame_err}, 32'd0);
         @(negedge clk);
      end

      // R5: every short length
      send(8'hA5, N, "R5 setup");
      @(negedge clk);
      for (int n = 1; n < N; n++) begin
         send(8'h3C ^ 8'(n), n, "R5 short");
         @(negedge clk);
         chk("R5 err one cycle", {30'b0, code_upd, frame_err}, 32'd0);
         chk("R5 code kept", 32'(dac_code), 32'hA5);
      end

      // R6: overlong frames
      for (int n = N + 1; n <= N + 3; n++) begin
         send(8'h69 + 8'(n), n, "R6 long");
         @(negedge clk);
      end

      // R8: back-to-back frames, one low sample between
      send(8'h12, N, "R8 tight a");
      send(8'hED, N, "R8 tight b");
      send(8'h0F, 3, "R8 tight short");
      send(8'hF0, N, "R8 tight c");
      @(negedge clk);
      chk("R8 final", 32'(dac_code), 32'hF0);

      // R1: reset after activity
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset again", 32'(dac_code), 32'd0);
      rst_n = 1'b1;
      exp_code = '0;
      @(negedge clk);
      send(8'h81, N, "R1 after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule